// File: doc/BRIEF.md
# Micro-Step Position Translator

This block converts a stream of step pulses into coil current targets for a two-phase bipolar stepper motor. It holds the rotor's electrical angle as a 7-bit index in units of 1/32 of a full step, giving 128 positions per electrical period. On every qualified edge of the step pin it moves that index by the increment of the active step mode, in the direction given by the direction pin and a direction-invert bit. From the index it derives two signed setpoints, one per coil, in tenths of a percent of the peak current. A downstream current regulator consumes them.

The step and direction pins are asynchronous. They pass through a synchronizer of `SYNC_STAGES` flops before edge detection. A requested step mode is held until the next qualified edge, and it is applied together with that step. When the resolution goes up, the index first snaps to the nearest point of the finer grid. When it goes down or stays equal, any offset from the new grid is kept. The circular modes follow a sine/cosine table. The two square modes drive each coil either at full scale or at zero.

Top module: `msp_translator`

## Requirements
- R1: With `step_fall` = 0 only a rising edge of `step_pin` is a step, and with `step_fall` = 1 only a falling edge is. The other edge changes nothing. `position` changes on the (`SYNC_STAGES`+1)-th rising clock edge after the pin changes.
- R2: After reset, `position` is 0 and the active mode is 1/32, so the outputs are X = 0 and Y = 1000.
- R3: Setpoints are signed tenths of a percent. Let Q[0..32] be 0, 35, 81, 127, 174, 221, 267, 314, 349, 383, 430, 465, 500, 546, 581, 616, 651, 686, 721, 755, 790, 826, 849, 872, 895, 918, 930, 941, 953, 965, 977, 988, 1000. For position p in a circular mode (codes 000 to 100 and 111), let k = p mod 32. X is +Q[k], +Q[32-k], -Q[k] or -Q[32-k] for p in 0..31, 32..63, 64..95 and 96..127 respectively. Y equals X evaluated at (p+32) mod 128. So p=0 gives (0,1000), p=16 gives (651,651) and p=32 gives (1000,0).
- R4: In the square modes (code 101 uncompensated half step, code 110 full step), X is 0 at p = 0 and p = 64, +1000 for p in 1..63, and -1000 for p in 65..127. Y follows the same rule at (p+32) mod 128.
- R5: A change on `mode_sel` alters neither `position` nor the setpoint shape until the next qualified step edge. At that edge the new mode takes effect.
- R6: The step is forward when `dir_pin` XOR `dir_invert` is 1, and backward otherwise. The increment for codes 000 to 110 is 1, 2, 4, 8, 16, 16 and 32 respectively. Code 111 acts like 000.
- R7: If the new mode's increment S is smaller than the active one, the position is first rounded to a multiple of S, with halves rounding up (floor((p + S/2)/S)·S mod 128). It then moves by S.
- R8: If the new increment is equal to or larger than the active one, the position moves by the increment with no rounding, so an offset from the new grid is kept.
- R9: With `drive_en` = 0 both setpoints are 0, yet steps still move `position`. When `drive_en` returns to 1, the outputs match the accumulated position.
- R10: The position wraps modulo 128 in both directions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| step_pin | input | 1 | Asynchronous step request pin |
| dir_pin | input | 1 | Asynchronous direction pin |
| dir_invert | input | 1 | Inverts the sense of `dir_pin` |
| step_fall | input | 1 | 0: rising edge steps, 1: falling edge steps |
| mode_sel | input | 3 | Requested step mode code |
| drive_en | input | 1 | Setpoints forced to zero when low |
| position | output | 7 | Electrical position in 1/32-step units |
| coil_x | output | 11 | Signed X-coil target, tenths of a percent |
| coil_y | output | 11 | Signed Y-coil target, tenths of a percent |

## Verification
Several properties are checked on every cycle. The edge detector never fires two cycles in a row under a fixed polarity. The position and active mode stay frozen between qualified edges, and every qualified edge moves the position. A rise in resolution always lands on the finer grid. While the drive is enabled, the square modes only produce 0 or full-scale values, never both zero together. The bench's scenarios are the only way to show the numeric sine values, the direction and invert sense, the kept offset on a resolution drop, the snap with halves rounding up, wrap-around, and counting while the drive is disabled. For these, a behavioural model built on queues and integers is compared with the outputs every cycle, alongside hand-worked directed checks.

// File: rtl/msp_pkg.sv
package msp_pkg;

    localparam int POS_W   = 7;
    localparam int COIL_W  = 11;
    localparam int MAG_W   = 10;
    localparam int QUARTER = 1 << (POS_W - 2);

    typedef logic [POS_W-1:0]         pos_t;
    typedef logic signed [COIL_W-1:0] coil_t;
    typedef logic [MAG_W-1:0]         mag_t;

    typedef enum logic [2:0] {
        MODE_32    = 3'd0,
        MODE_16    = 3'd1,
        MODE_8     = 3'd2,
        MODE_4     = 3'd3,
        MODE_HALF  = 3'd4,
        MODE_HALFQ = 3'd5,
        MODE_FULL  = 3'd6,
        MODE_RSVD  = 3'd7
    } step_mode_e;

    typedef struct packed {
        coil_t x;
        coil_t y;
    } coil_pair_t;

    localparam coil_t FULL_POS = coil_t'(1000);
    localparam coil_t FULL_NEG = -coil_t'(1000);

    function automatic pos_t step_size(step_mode_e m);
        case (m)
            MODE_16:    return pos_t'(2);
            MODE_8:     return pos_t'(4);
            MODE_4:     return pos_t'(8);
            MODE_HALF:  return pos_t'(16);
            MODE_HALFQ: return pos_t'(16);
            MODE_FULL:  return pos_t'(32);
            default:    return pos_t'(1);
        endcase
    endfunction

    function automatic logic is_square(step_mode_e m);
        return (m == MODE_HALFQ) || (m == MODE_FULL);
    endfunction

    // Quarter-wave magnitude, tenths of a percent, index 0..32.
    function automatic mag_t quarter_mag(logic [5:0] k);
        case (k)
            6'd0:  return mag_t'(0);
            6'd1:  return mag_t'(35);
            6'd2:  return mag_t'(81);
            6'd3:  return mag_t'(127);
            6'd4:  return mag_t'(174);
            6'd5:  return mag_t'(221);
            6'd6:  return mag_t'(267);
            6'd7:  return mag_t'(314);
            6'd8:  return mag_t'(349);
            6'd9:  return mag_t'(383);
            6'd10: return mag_t'(430);
            6'd11: return mag_t'(465);
            6'd12: return mag_t'(500);
            6'd13: return mag_t'(546);
            6'd14: return mag_t'(581);
            6'd15: return mag_t'(616);
            6'd16: return mag_t'(651);
            6'd17: return mag_t'(686);
            6'd18: return mag_t'(721);
            6'd19: return mag_t'(755);
            6'd20: return mag_t'(790);
            6'd21: return mag_t'(826);
            6'd22: return mag_t'(849);
            6'd23: return mag_t'(872);
            6'd24: return mag_t'(895);
            6'd25: return mag_t'(918);
            6'd26: return mag_t'(930);
            6'd27: return mag_t'(941);
            6'd28: return mag_t'(953);
            6'd29: return mag_t'(965);
            6'd30: return mag_t'(977);
            6'd31: return mag_t'(988);
            default: return mag_t'(1000);
        endcase
    endfunction

    function automatic coil_t circ_value(pos_t p);
        logic [5:0] idx;
        mag_t       mag;
        idx = p[POS_W-2] ? (6'(QUARTER) - {1'b0, p[POS_W-3:0]}) : {1'b0, p[POS_W-3:0]};
        mag = quarter_mag(idx);
        return p[POS_W-1] ? -coil_t'({1'b0, mag}) : coil_t'({1'b0, mag});
    endfunction

    function automatic coil_t square_value(pos_t p);
        if (p[POS_W-2:0] == '0) return '0;
        return p[POS_W-1] ? FULL_NEG : FULL_POS;
    endfunction

    function automatic coil_pair_t coil_targets(pos_t p, step_mode_e m);
        coil_pair_t r;
        pos_t       py;
        py = p + pos_t'(QUARTER);
        if (is_square(m)) begin
            r.x = square_value(p);
            r.y = square_value(py);
        end else begin
            r.x = circ_value(p);
            r.y = circ_value(py);
        end
        return r;
    endfunction

endpackage

// File: rtl/msp_edge_sync.sv
module msp_edge_sync
    import msp_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic step_raw,
    input  logic dir_raw,
    input  logic dir_invert,
    input  logic fall_sel,
    output logic fire,
    output logic dir_fwd
);
    localparam int LAST = SYNC_STAGES - 1;

    logic [LAST:0] step_sh;
    logic [LAST:0] dir_sh;
    logic          step_prev;

    generate
        if (SYNC_STAGES == 1) begin : g_single
            always_ff @(posedge clk) begin
                if (rst) begin
                    step_sh <= '0;
                    dir_sh  <= '0;
                end else begin
                    step_sh <= step_raw;
                    dir_sh  <= dir_raw;
                end
            end
        end else begin : g_chain
            always_ff @(posedge clk) begin
                if (rst) begin
                    step_sh <= '0;
                    dir_sh  <= '0;
                end else begin
                    step_sh <= {step_sh[LAST-1:0], step_raw};
                    dir_sh  <= {dir_sh[LAST-1:0], dir_raw};
                end
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) step_prev <= 1'b0;
        else     step_prev <= step_sh[LAST];
    end

    logic rise_seen, fall_seen;
    always_comb begin
        rise_seen = step_sh[LAST] & ~step_prev;
        fall_seen = ~step_sh[LAST] & step_prev;
        fire      = fall_sel ? fall_seen : rise_seen;
        dir_fwd   = dir_sh[LAST] ^ dir_invert;
    end

    // R1: one qualified edge yields a single-cycle pulse under steady polarity
    p_single_fire_r1: assert property (@(posedge clk) disable iff (rst)
        fire |=> (!fire || (fall_sel != $past(fall_sel))));

endmodule

// File: rtl/msp_position.sv
module msp_position
    import msp_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       fire,
    input  logic       dir_fwd,
    input  step_mode_e mode_req,
    output pos_t       pos,
    output step_mode_e mode_act
);
    pos_t size_new, size_cur, base, nxt;

    always_comb begin
        size_new = step_size(mode_req);
        size_cur = step_size(mode_act);
        base     = pos;
        if (size_new < size_cur)
            base = (pos + (size_new >> 1)) & ~(size_new - pos_t'(1));
        nxt = dir_fwd ? (base + size_new) : (base - size_new);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pos      <= '0;
            mode_act <= MODE_32;
        end else if (fire) begin
            pos      <= nxt;
            mode_act <= mode_req;
        end
    end

    // R5: nothing moves between qualified edges
    p_hold_between_r5: assert property (@(posedge clk) disable iff (rst)
        !fire |=> ($stable(pos) && $stable(mode_act)));

    // R6: every qualified edge changes the position
    p_edge_moves_r6: assert property (@(posedge clk) disable iff (rst)
        fire |=> (pos != $past(pos)));

    // R7: a finer resolution always lands on its own grid
    p_snap_grid_r7: assert property (@(posedge clk) disable iff (rst)
        (fire && (step_size(mode_req) < step_size(mode_act)))
        |=> ((pos & (step_size(mode_act) - pos_t'(1))) == '0));

endmodule

// File: rtl/msp_translator.sv
module msp_translator
    import msp_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     step_pin,
    input  logic                     dir_pin,
    input  logic                     dir_invert,
    input  logic                     step_fall,
    input  logic [2:0]               mode_sel,
    input  logic                     drive_en,
    output logic [POS_W-1:0]         position,
    output logic signed [COIL_W-1:0] coil_x,
    output logic signed [COIL_W-1:0] coil_y
);
    logic       fire, dir_fwd;
    pos_t       pos;
    step_mode_e mode_act;
    coil_pair_t tgt;

    msp_edge_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk        (clk),
        .rst        (rst),
        .step_raw   (step_pin),
        .dir_raw    (dir_pin),
        .dir_invert (dir_invert),
        .fall_sel   (step_fall),
        .fire       (fire),
        .dir_fwd    (dir_fwd)
    );

    msp_position u_pos (
        .clk      (clk),
        .rst      (rst),
        .fire     (fire),
        .dir_fwd  (dir_fwd),
        .mode_req (step_mode_e'(mode_sel)),
        .pos      (pos),
        .mode_act (mode_act)
    );

    always_comb begin
        tgt      = coil_targets(pos, mode_act);
        position = pos;
        coil_x   = drive_en ? tgt.x : '0;
        coil_y   = drive_en ? tgt.y : '0;
    end

    // R4: square modes drive only 0 or full scale, never both coils at zero
    p_square_levels_r4: assert property (@(posedge clk) disable iff (rst)
        (drive_en && is_square(mode_act)) |->
        ((coil_x == '0 || coil_x == FULL_POS || coil_x == FULL_NEG) &&
         (coil_y == '0 || coil_y == FULL_POS || coil_y == FULL_NEG) &&
         !(coil_x == '0 && coil_y == '0)));

endmodule

// File: tb/test_msp_translator.sv
module test_msp_translator;

    localparam int SYNC = 2;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic step_pin = 1'b0, dir_pin = 1'b1, dir_invert = 1'b0, step_fall = 1'b0;
    logic [2:0] mode_sel = 3'd0;
    logic drive_en = 1'b1;
    logic [6:0] position;
    logic signed [10:0] coil_x, coil_y;

    int tests = 0;
    int fails = 0;
    bit model_on = 0;

    always #2 clk = ~clk;

    msp_translator #(.SYNC_STAGES(SYNC)) i_msp_translator (
        .clk(clk), .rst(rst), .step_pin(step_pin), .dir_pin(dir_pin),
        .dir_invert(dir_invert), .step_fall(step_fall), .mode_sel(mode_sel),
        .drive_en(drive_en), .position(position), .coil_x(coil_x), .coil_y(coil_y)
    );

    int qtab [33] = '{0, 35, 81, 127, 174, 221, 267, 314, 349, 383, 430, 465, 500,
                      546, 581, 616, 651, 686, 721, 755, 790, 826, 849, 872, 895,
                      918, 930, 941, 953, 965, 977, 988, 1000};

    function automatic int incr_of(int m);
        case (m)
            1: return 2;  2: return 4;  3: return 8;
            4: return 16; 5: return 16; 6: return 32;
            default: return 1;
        endcase
    endfunction

    function automatic int sine_of(int p);
        int quad = p / 32;
        int k = p % 32;
        int mag = (quad % 2 == 0) ? qtab[k] : qtab[32 - k];
        return (quad >= 2) ? -mag : mag;
    endfunction

    function automatic int square_of(int p);
        if (p % 64 == 0) return 0;
        return (p < 64) ? 1000 : -1000;
    endfunction

    function automatic int coil_of(int p, int m, bit en);
        if (!en) return 0;
        if (m == 5 || m == 6) return square_of(p);
        return sine_of(p);
    endfunction

    // Behavioural reference
    int q_step[$];
    int q_dir[$];
    int m_prev, m_pos, m_mode;

    always @(posedge clk) begin
        if (rst) begin
            q_step.delete(); q_dir.delete();
            for (int i = 0; i < SYNC; i++) begin q_step.push_back(0); q_dir.push_back(0); end
            m_prev = 0; m_pos = 0; m_mode = 0;
        end else begin
            int a, d, s;
            bit hit, fwd;
            a = q_step.pop_front();
            d = q_dir.pop_front();
            q_step.push_back(int'(step_pin));
            q_dir.push_back(int'(dir_pin));
            hit = step_fall ? (m_prev == 1 && a == 0) : (m_prev == 0 && a == 1);
            m_prev = a;
            if (hit) begin
                s = incr_of(int'(mode_sel));
                fwd = (d != 0) ^ dir_invert;
                if (s < incr_of(m_mode)) m_pos = (((m_pos + s / 2) / s) * s) % 128;
                m_pos = (m_pos + (fwd ? s : 128 - s)) % 128;
                m_mode = int'(mode_sel);
            end
        end
    end

    always @(negedge clk) begin
        if (model_on && !rst) begin
            int ex, ey;
            ex = coil_of(m_pos, m_mode, drive_en);
            ey = coil_of((m_pos + 32) % 128, m_mode, drive_en);
            tests++;
            if (int'(position) != m_pos || int'(coil_x) != ex || int'(coil_y) != ey) begin
                fails++;
                $display("FAIL R3/R6/model: pos=%0d x=%0d y=%0d expected pos=%0d x=%0d y=%0d",
                         position, coil_x, coil_y, m_pos, ex, ey);
            end
        end
    end

    task automatic chk(string req, int act, int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic toggle_pin();
        step_pin = !step_pin;
        repeat (4) @(negedge clk);
    endtask

    task automatic pulse();
        toggle_pin();
        toggle_pin();
    endtask

    task automatic finish_run();
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: run did not finish");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        model_on = 1;
        @(negedge clk);
        // R2: reset state
        chk("R2 pos", int'(position), 0);
        chk("R2 x", int'(coil_x), 0);
        chk("R2 y", int'(coil_y), 1000);

        // R1 R3: sixteen rising-edge steps at 1/32
        for (int i = 0; i < 16; i++) pulse();
        chk("R1 pos", int'(position), 16);
        chk("R3 x", int'(coil_x), 651);
        chk("R3 y", int'(coil_y), 651);

        // R5: mode request alone changes nothing
        mode_sel = 3'd6;
        repeat (6) @(negedge clk);
        chk("R5 pos", int'(position), 16);
        chk("R5 x", int'(coil_x), 651);

        // R4 R8: full step from 16 keeps the grid
        pulse();
        chk("R8 pos", int'(position), 48);
        chk("R4 x", int'(coil_x), 1000);
        chk("R4 y", int'(coil_y), -1000);

        mode_sel = 3'd5;
        pulse();
        chk("R4 half pos", int'(position), 64);
        chk("R4 half x", int'(coil_x), 0);
        chk("R4 half y", int'(coil_y), -1000);

        // R9: disabled outputs, steps still counted
        drive_en = 1'b0;
        @(negedge clk);
        chk("R9 x off", int'(coil_x), 0);
        chk("R9 y off", int'(coil_y), 0);
        pulse();
        chk("R9 pos", int'(position), 80);
        drive_en = 1'b1;
        @(negedge clk);
        chk("R9 x on", int'(coil_x), -1000);
        chk("R9 y on", int'(coil_y), -1000);

        // R6: backward in 1/32
        mode_sel = 3'd0; dir_pin = 1'b0;
        pulse();
        chk("R6 back", int'(position), 79);

        // R8: coarser mode keeps the offset
        mode_sel = 3'd4; dir_pin = 1'b1;
        pulse();
        chk("R8 offset", int'(position), 95);

        // R7: finer mode snaps then steps
        mode_sel = 3'd3;
        pulse();
        chk("R7 pos", int'(position), 104);
        chk("R7 x", int'(coil_x), -895);
        chk("R7 y", int'(coil_y), 349);

        // R6: invert bit reverses direction
        dir_invert = 1'b1;
        pulse();
        chk("R6 invert", int'(position), 96);

        // R1: falling-edge polarity, rising edge ignored
        step_fall = 1'b1;
        toggle_pin();
        chk("R1 rise ignored", int'(position), 96);
        toggle_pin();
        chk("R1 fall steps", int'(position), 88);
        step_fall = 1'b0; dir_invert = 1'b0;

        // R10: wrap forward
        mode_sel = 3'd6;
        pulse();
        pulse();
        chk("R10 wrap", int'(position), 24);

        // Mixed stimulus against the model
        for (int i = 0; i < 300; i++) begin
            mode_sel   = 3'($urandom % 8);
            dir_pin    = 1'($urandom % 2);
            dir_invert = 1'($urandom % 2);
            drive_en   = ($urandom % 5) != 0;
            if ($urandom % 10 == 0) step_fall = !step_fall;
            toggle_pin();
            if ($urandom % 3 == 0) repeat (2) @(negedge clk);
        end

        finish_run();
    end

endmodule